// File: doc/BRIEF.md
# Three-Wire SPI Command Shifter

This block is a bit-level SPI master for a serial memory wired with a single shared data line. A start pulse loads a left-aligned command word and a length code. The block then frames chip-select with a short high pulse, drives it low, and shifts the top 2, 8, 16 or 32 bits of the word out most significant first. On the last transmitted bit it stops driving the data line while SCK is still high, so the memory can take the line over after the falling edge.

Chip-select stays low when the command ends. A receive request can follow and clocks in one byte from the same line. A release input ends any activity, drives chip-select high and turns off every pin driver until the next command. The SCK phases and the chip-select pulse are stretched to parameterized minimum lengths in cycles.

Top module: `spi3w_cmd_shifter`

## Requirements
- R1: After reset, `cs_o` is 1, `cs_oe_o`, `sck_oe_o` and `dq_oe_o` are 0, and `busy_o` and `rx_valid_o` are 0.
- R2: `cmd_len_i` selects the command length: 2'b00 gives 2 bits, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32. A command produces exactly that many SCK rising edges.
- R3: Bit k of a command (k = 0 first) is `cmd_word_i[31-k]`, as captured at the start pulse. It is placed on `dq_o` during the SCK low phase that comes before rise k.
- R4: Each command begins with `cs_o` high and `cs_oe_o` high for exactly `CSH_CYC` cycles, after which `cs_o` goes low.
- R5: Each SCK low phase and each SCK high phase lasts exactly `HALF_CYC` cycles. `busy_o` is high for exactly `CSH_CYC + 2*HALF_CYC*n` cycles after the start edge, where n is the bit count.
- R6: `dq_oe_o` is 1 in the low phase of every transmitted bit. It is also 1 in the high phase of every bit except the last, and 0 in the high phase of the last bit.
- R7: When a command completes, `cs_o` stays low with `cs_oe_o` and `sck_oe_o` still high.
- R8: A receive request, made while idle and not released, gives 8 SCK pulses. `dq_i` is sampled in the last cycle of each high phase and shifted in at bit 0, so the first bit ends in bit 7. `rx_valid_o` is high for a single cycle, `16*HALF_CYC` cycles after the request edge, with the byte on `rx_byte_o`.
- R9: A start or receive request made while `busy_o` is high is ignored. The running transfer keeps its bits, length and timing.
- R10: A release takes effect at the next edge, even in the middle of a transfer. The block then shows `cs_o` = 1, all output enables 0 and `busy_o` = 0. Receive requests are ignored while released, and the next start pulse leaves the released state.
- R11: `dq_oe_o` stays 0 throughout a receive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_word_i | input | 32 | Left-aligned command bits |
| cmd_len_i | input | 2 | Length code: 2, 8, 16 or 32 bits |
| cmd_start_i | input | 1 | Start a command (one-cycle pulse) |
| rx_req_i | input | 1 | Receive one byte |
| release_i | input | 1 | Deselect and float all pins |
| dq_i | input | 1 | Data line input |
| busy_o | output | 1 | Transfer in progress |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle strobe, byte ready |
| cs_o | output | 1 | Chip-select, active low |
| cs_oe_o | output | 1 | Chip-select driver enable |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | Serial clock driver enable |
| dq_o | output | 1 | Data line output value |
| dq_oe_o | output | 1 | Data line driver enable |

## Verification
A command is due `CSH_CYC + 2*HALF_CYC*n` cycles after the edge that takes its start pulse. A received byte is due `16*HALF_CYC` cycles after its request edge, and a release shows one edge after it is sampled. The bench drives every input just after a falling clock edge and counts falling edges while `busy_o` is high, then compares that count with the due cycle exactly. A pin monitor runs on the falling edge and records the data and enable values of the low phase before each SCK rise, the enable at the rise, the width of the chip-select pulse and the total SCK high time. These records are compared against the expected bits only after `busy_o` drops.

// File: rtl/spi3w_pkg.sv
package spi3w_pkg;
  localparam int CMD_W = 32;
  localparam int BW    = $clog2(CMD_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSH,
    ST_TXL,
    ST_TXH,
    ST_RXL,
    ST_RXH
  } st_e;

  function automatic logic [BW-1:0] len_decode(input logic [1:0] code);
    case (code)
      2'b00:   return BW'(2);
      2'b01:   return BW'(8);
      2'b10:   return BW'(16);
      default: return BW'(CMD_W);
    endcase
  endfunction
endpackage

// File: rtl/spi3w_phase_timer.sv
module spi3w_phase_timer #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic [W-1:0] len_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + W'(1);
  end

  assign last_o = (cnt_q == len_i - W'(1));

  p_cnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_i);
endmodule

// File: rtl/spi3w_tx_shifter.sv
module spi3w_tx_shifter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  input  logic         shift_i,
  output logic         msb_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= data_i;
    else if (shift_i) sr_q <= {sr_q[W-2:0], 1'b0};
  end

  assign msb_o = sr_q[W-1];

  p_next_bit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_i && !load_i) |=> (msb_o == $past(sr_q[W-2])));
endmodule

// File: rtl/spi3w_rx_shifter.sv
module spi3w_rx_shifter #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         sample_i,
  input  logic         bit_i,
  output logic [W-1:0] byte_o
);
  logic [W-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sr_q <= '0;
    else if (clr_i)    sr_q <= '0;
    else if (sample_i) sr_q <= {sr_q[W-2:0], bit_i};
  end

  assign byte_o = sr_q;

  p_shift_in_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_i && !clr_i) |=> (byte_o[0] == $past(bit_i)));
endmodule

// File: rtl/spi3w_cmd_shifter.sv
module spi3w_cmd_shifter
  import spi3w_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int CSH_CYC  = 2,
  parameter int RX_BITS  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CMD_W-1:0]   cmd_word_i,
  input  logic [1:0]         cmd_len_i,
  input  logic               cmd_start_i,
  input  logic               rx_req_i,
  input  logic               release_i,
  input  logic               dq_i,
  output logic               busy_o,
  output logic [RX_BITS-1:0] rx_byte_o,
  output logic               rx_valid_o,
  output logic               cs_o,
  output logic               cs_oe_o,
  output logic               sck_o,
  output logic               sck_oe_o,
  output logic               dq_o,
  output logic               dq_oe_o
);
  localparam int PH_MAX = (CSH_CYC > HALF_CYC) ? CSH_CYC : HALF_CYC;
  localparam int CW     = $clog2(PH_MAX + 1);

  st_e           st_q;
  logic          rel_q;
  logic [BW-1:0] bits_left_q;
  logic          rx_valid_q;
  logic          ph_last;
  logic [CW-1:0] ph_len;
  logic          last_bit;
  logic          tx_load, tx_shift, rx_clr, rx_sample, tx_msb;
  logic          go_tx, go_rx;

  assign last_bit = (bits_left_q == BW'(1));
  assign go_tx    = (st_q == ST_IDLE) && cmd_start_i && !release_i;
  assign go_rx    = (st_q == ST_IDLE) && rx_req_i && !cmd_start_i && !rel_q && !release_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      rel_q       <= 1'b1;
      bits_left_q <= '0;
      rx_valid_q  <= 1'b0;
    end else begin
      rx_valid_q <= 1'b0;
      if (release_i) begin
        st_q        <= ST_IDLE;
        rel_q       <= 1'b1;
        bits_left_q <= '0;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (go_tx) begin
              st_q        <= ST_CSH;
              rel_q       <= 1'b0;
              bits_left_q <= len_decode(cmd_len_i);
            end else if (go_rx) begin
              st_q        <= ST_RXL;
              bits_left_q <= BW'(RX_BITS);
            end
          end
          ST_CSH: if (ph_last) st_q <= ST_TXL;
          ST_TXL: if (ph_last) st_q <= ST_TXH;
          ST_TXH: if (ph_last) begin
            bits_left_q <= bits_left_q - BW'(1);
            st_q        <= last_bit ? ST_IDLE : ST_TXL;
          end
          ST_RXL: if (ph_last) st_q <= ST_RXH;
          ST_RXH: if (ph_last) begin
            bits_left_q <= bits_left_q - BW'(1);
            if (last_bit) begin
              st_q       <= ST_IDLE;
              rx_valid_q <= 1'b1;
            end else begin
              st_q <= ST_RXL;
            end
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign ph_len = (st_q == ST_CSH) ? CW'(CSH_CYC) : CW'(HALF_CYC);

  spi3w_phase_timer #(.W(CW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  ((st_q == ST_IDLE) || ph_last || release_i),
    .len_i  (ph_len),
    .last_o (ph_last)
  );

  assign tx_load  = go_tx;
  assign tx_shift = (st_q == ST_TXH) && ph_last;

  spi3w_tx_shifter #(.W(CMD_W)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (tx_load),
    .data_i  (cmd_word_i),
    .shift_i (tx_shift),
    .msb_o   (tx_msb)
  );

  assign rx_clr    = go_rx;
  assign rx_sample = (st_q == ST_RXH) && ph_last;

  spi3w_rx_shifter #(.W(RX_BITS)) u_rx (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (rx_clr),
    .sample_i (rx_sample),
    .bit_i    (dq_i),
    .byte_o   (rx_byte_o)
  );

  // CS high only in the framing pulse and while released
  assign cs_o       = (st_q == ST_CSH) || ((st_q == ST_IDLE) && rel_q);
  assign cs_oe_o    = !rel_q;
  assign sck_oe_o   = !rel_q;
  assign sck_o      = (st_q == ST_TXH) || (st_q == ST_RXH);
  assign dq_o       = tx_msb;
  // turnaround: release the line in the high phase of the final bit
  assign dq_oe_o    = (st_q == ST_TXL) || ((st_q == ST_TXH) && !last_bit);
  assign busy_o     = (st_q != ST_IDLE);
  assign rx_valid_o = rx_valid_q;

  p_release_float_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_i |=> (cs_o && !cs_oe_o && !sck_oe_o && !dq_oe_o && !busy_o));

  p_rx_no_drive_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_RXL) || (st_q == ST_RXH)) |-> !dq_oe_o);

  p_cs_held_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_TXH) && ph_last && last_bit && !release_i)
      |=> (!cs_o && cs_oe_o && !busy_o));

  p_turnaround_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_TXH) && ph_last && last_bit) |-> !dq_oe_o);

  p_valid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st_q == ST_CSH) && !release_i) |=> $stable(bits_left_q));
endmodule

// File: tb/tb_spi3w_cmd_shifter.sv
`timescale 1ns/1ps
module tb_spi3w_cmd_shifter;
  localparam int HALF = 2;
  localparam int CSH  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [1:0]  cmd_len = '0;
  logic        cmd_start = 1'b0, rx_req = 1'b0, rel = 1'b0, dq_in = 1'b0;
  logic        busy, rx_valid, cs, cs_oe, sck, sck_oe, dq_out, dq_oe;
  logic [7:0]  rx_byte;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  spi3w_cmd_shifter #(.HALF_CYC(HALF), .CSH_CYC(CSH), .RX_BITS(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_word_i(cmd_word), .cmd_len_i(cmd_len),
    .cmd_start_i(cmd_start), .rx_req_i(rx_req), .release_i(rel), .dq_i(dq_in),
    .busy_o(busy), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .cs_o(cs),
    .cs_oe_o(cs_oe), .sck_o(sck), .sck_oe_o(sck_oe), .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  // pin monitor
  logic        prev_sck = 0, prev_dq = 0, prev_oe = 0;
  logic [31:0] cap_dq, cap_setup_oe, cap_hi_oe;
  int          rise_cnt = 0, hi_cycles = 0, cs_run = 0, cs_pulse = 0;
  logic        rx_active = 0, rx_oe_seen = 0;
  logic [7:0]  rx_shift = 0;

  always @(negedge clk) begin
    if (!prev_sck && sck) begin
      if (rise_cnt < 32) begin
        cap_dq[rise_cnt]       = prev_dq;
        cap_setup_oe[rise_cnt] = prev_oe;
        cap_hi_oe[rise_cnt]    = dq_oe;
      end
      rise_cnt++;
    end
    if (sck) hi_cycles++;
    if (cs_oe && cs) cs_run++;
    else if (cs_run != 0) begin cs_pulse = cs_run; cs_run = 0; end
    if (rx_active && dq_oe) rx_oe_seen = 1;
    if (rx_active && prev_sck && !sck) begin
      rx_shift = {rx_shift[6:0], 1'b0};
      dq_in    = rx_shift[7];
    end
    prev_sck = sck; prev_dq = dq_out; prev_oe = dq_oe;
  end

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int nbits(input logic [1:0] code);
    case (code)
      2'b00: return 2;
      2'b01: return 8;
      2'b10: return 16;
      default: return 32;
    endcase
  endfunction

  task automatic send_cmd(input logic [31:0] word, input logic [1:0] code, input bit poke);
    int n = nbits(code);
    int cyc = 0;
    bit bits_ok = 1, oe_ok = 1;
    rise_cnt = 0; hi_cycles = 0; cs_pulse = 0;
    cmd_word = word; cmd_len = code; cmd_start = 1'b1;
    step();
    cmd_start = 1'b0;
    while (busy && cyc < 5000) begin
      cyc++;
      if (poke && cyc == 4) begin
        cmd_start = 1'b1; rx_req = 1'b1; cmd_word = ~word; cmd_len = ~code;
      end else begin
        cmd_start = 1'b0; rx_req = 1'b0;
      end
      step();
    end
    cmd_start = 1'b0; rx_req = 1'b0;
    chk(cyc == CSH + 2*HALF*n, poke ? "R9 busy length with poke" : "R5 busy length", cyc, CSH + 2*HALF*n);
    chk(rise_cnt == n, "R2 SCK rises", rise_cnt, n);
    chk(hi_cycles == n*HALF, "R5 SCK high time", hi_cycles, n*HALF);
    for (int k = 0; k < n; k++) begin
      if (cap_dq[k] != word[31-k]) bits_ok = 0;
      if (!cap_setup_oe[k] || (cap_hi_oe[k] != (k != n-1))) oe_ok = 0;
    end
    chk(bits_ok, "R3 bit order", cap_dq, word);
    chk(oe_ok, "R6 turnaround", cap_hi_oe, 0);
    chk(cs_pulse == CSH, "R4 CS pulse", cs_pulse, CSH);
    chk(!cs && cs_oe && sck_oe, "R7 CS held low", {cs, cs_oe, sck_oe}, 3'b011);
  endtask

  task automatic read_byte(input logic [7:0] val);
    int cyc = 0;
    rise_cnt = 0; rx_oe_seen = 0;
    rx_shift = val; dq_in = val[7]; rx_active = 1;
    rx_req = 1'b1;
    step();
    rx_req = 1'b0;
    while (busy && cyc < 5000) begin cyc++; step(); end
    chk(cyc == 8*2*HALF, "R8 receive length", cyc, 16*HALF);
    chk(rx_valid == 1'b1, "R8 valid strobe", rx_valid, 1);
    chk(rx_byte == val, "R8 received byte", rx_byte, val);
    chk(rise_cnt == 8, "R8 SCK rises", rise_cnt, 8);
    chk(!rx_oe_seen, "R11 no drive in receive", rx_oe_seen, 0);
    step();
    chk(rx_valid == 1'b0, "R8 valid one cycle", rx_valid, 0);
    rx_active = 0;
  endtask

  // code in [33:32], word in [31:0]
  localparam logic [33:0] VEC [7] = '{
    {2'b00, 32'h8000_0000},
    {2'b00, 32'h4000_0000},
    {2'b01, 32'h66FF_FFFF},
    {2'b01, 32'h9900_0000},
    {2'b10, 32'hA5C3_0000},
    {2'b11, 32'h03DE_AD01},
    {2'b11, 32'hFFFF_FFFE}
  };

  initial begin
    repeat (1000000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1'b1;
    step();
    // R1
    chk(cs && !cs_oe && !sck_oe && !dq_oe, "R1 reset pins", {cs, cs_oe, sck_oe, dq_oe}, 4'b1000);
    chk(!busy && !rx_valid, "R1 reset status", {busy, rx_valid}, 0);

    // R10: receive ignored while released after reset
    rise_cnt = 0;
    rx_req = 1'b1;
    for (int i = 0; i < 6; i++) step();
    rx_req = 1'b0;
    chk(!busy && rise_cnt == 0 && !rx_valid, "R10 receive ignored when released", rise_cnt, 0);

    for (int i = 0; i < 7; i++) send_cmd(VEC[i][31:0], VEC[i][33:32], 1'b0);

    read_byte(8'hA5);
    read_byte(8'h3C);

    // R9
    send_cmd(32'h0500_0000, 2'b01, 1'b1);
    send_cmd(32'hC000_0000, 2'b00, 1'b1);

    // R10: release mid-command
    cmd_word = 32'hFFFF_FFFF; cmd_len = 2'b11; cmd_start = 1'b1;
    step();
    cmd_start = 1'b0;
    for (int i = 0; i < 7; i++) step();
    rel = 1'b1;
    step();
    rel = 1'b0;
    chk(cs && !cs_oe && !sck_oe && !dq_oe && !busy, "R10 release pins",
        {cs, cs_oe, sck_oe, dq_oe, busy}, 5'b10000);
    rise_cnt = 0;
    rx_req = 1'b1;
    for (int i = 0; i < 6; i++) step();
    rx_req = 1'b0;
    chk(!busy && rise_cnt == 0 && cs, "R10 receive ignored after release", rise_cnt, 0);

    // R10: start leaves released state
    send_cmd(32'h0300_0000, 2'b01, 1'b0);
    read_byte(8'h81);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule